// File: doc/BRIEF.md
# Timed Wash-Cycle Motor Sequencer

This block drives the direction lamps of a washer drum motor and keeps the wash timer. A rising edge on the start button begins a wash. The drum then cycles through four phases: forward spin, a rest, reverse spin and a second rest. The cycle repeats while wash time remains. The remaining time starts at fifteen minutes and counts down in whole minutes. It is presented as two BCD digits, which an external display driver multiplexes onto seven-segment digits.

A one-second tick arrives as a single-cycle input pulse, so the block does no clock division of its own. Every phase length and the minute length come from tick counts. When the minute count reaches zero, the motor lamps go dark and a done flag is raised. The done flag stays set until a new start edge or a reset. All pins are plain control and status signals; no data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `wash_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle: all three lamps low, `done` low, both digits 0.
- R2: A rising edge of `start_btn` seen while idle or done loads the count to BCD 15 (`min_tens`=1, `min_ones`=5), clears `done` and begins the forward phase with the phase timer at zero.
- R3: While running, the phases follow the tick count since start, modulo 60: ticks 0-19 forward, 20-29 pause, 30-49 reverse, 50-59 pause.
- R4: Lamps use the order {`lamp_fwd`, `lamp_rev`, `lamp_pause`}. Exactly one lamp is high while running, and none is high while idle or done.
- R5: Every 60th tick after start decrements the count by one minute. The BCD decrement borrows from the tens digit (10 becomes 09), both digits always hold 0-9, and the count changes only on a tick or a start edge.
- R6: The tick that takes the count from 01 to 00 ends the wash: the lamps go low and `done` goes high. `done` stays high with the count at 00 until a start edge or a reset.
- R7: A start edge while running has no effect. A start button held high does not retrigger; only a low-to-high transition counts.
- R8: Ticks while idle or done change neither the count nor the lamps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start button level, already debounced |
| sec_tick | input | 1 | One-cycle pulse once per second |
| lamp_fwd | output | 1 | Forward spin lamp |
| lamp_rev | output | 1 | Reverse spin lamp |
| lamp_pause | output | 1 | Pause lamp |
| done | output | 1 | Wash complete flag |
| min_tens | output | 4 | Remaining minutes, BCD tens digit |
| min_ones | output | 4 | Remaining minutes, BCD ones digit |

## Verification
The main run is driven with one unbroken train of ticks from start to finish. The outputs are sampled at every phase boundary, at the tick before and after each boundary, and at the minute steps that cross 10 to 09 and 01 to 00. This separates off-by-one phase lengths from wrong phase order and from a missing BCD borrow. Further patterns apply ticks with no wash in progress, hold the start level high across many ticks, and pulse start in the middle of a run. Those three separate level-triggered starts from edge-triggered ones, and a restart while busy from a correctly ignored one. A restart after done and a reset during a run confirm how the count reloads and how it clears.

// File: rtl/wash_pkg.sv
package wash_pkg;
  typedef enum logic [1:0] {PH_FWD, PH_REST_A, PH_REV, PH_REST_B} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
endpackage

// File: rtl/wash_edge.sv
module wash_edge (
  input  logic clk,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // tracks the level in every cycle, reset included, so a button held through reset is not an edge
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/wash_phase_timer.sv
module wash_phase_timer #(
  parameter int FWD_S  = 20,
  parameter int RESTA_S = 10,
  parameter int REV_S  = 20,
  parameter int RESTB_S = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                run,
  input  logic                tick,
  output wash_pkg::phase_e    phase,
  output logic                min_pulse
);
  import wash_pkg::*;

  localparam int CYCLE = FWD_S + RESTA_S + REV_S + RESTB_S;
  localparam int W     = $clog2(CYCLE);
  localparam logic [W-1:0] END_FWD   = W'(FWD_S);
  localparam logic [W-1:0] END_RESTA = W'(FWD_S + RESTA_S);
  localparam logic [W-1:0] END_REV   = W'(FWD_S + RESTA_S + REV_S);
  localparam logic [W-1:0] LAST      = W'(CYCLE - 1);

  logic [W-1:0] sec_q;
  logic         wrap;

  assign wrap      = (sec_q == LAST);
  assign min_pulse = run & tick & wrap;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sec_q <= '0;
    end else if (run && tick) begin
      sec_q <= wrap ? '0 : sec_q + 1'b1;
    end
  end

  always_comb begin
    if (sec_q < END_FWD)        phase = PH_FWD;
    else if (sec_q < END_RESTA) phase = PH_REST_A;
    else if (sec_q < END_REV)   phase = PH_REV;
    else                        phase = PH_REST_B;
  end
endmodule

// File: rtl/wash_bcd_down.sv
module wash_bcd_down #(
  parameter int                  NDIG   = 2,
  parameter logic [4*NDIG-1:0]   PRESET = 8'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              dec,
  output logic [4*NDIG-1:0] digits,
  output logic              at_one
);
  logic [NDIG-1:0] brw;
  logic            at_zero;

  assign at_zero = (digits == '0);
  assign at_one  = (digits == (4*NDIG)'(1));
  assign brw[0]  = dec & ~at_zero;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] d;
    assign digits[4*i +: 4] = d;

    if (i < NDIG - 1) begin : g_brw
      assign brw[i+1] = brw[i] & (d == 4'd0);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        d <= 4'd0;
      end else if (load) begin
        d <= PRESET[4*i +: 4];
      end else if (brw[i]) begin
        d <= (d == 4'd0) ? 4'd9 : d - 4'd1;
      end
    end
  end
endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer #(
  parameter int         FWD_S   = 20,
  parameter int         RESTA_S = 10,
  parameter int         REV_S   = 20,
  parameter int         RESTB_S = 10,
  parameter logic [7:0] PRESET  = 8'h15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_btn,
  input  logic       sec_tick,
  output logic       lamp_fwd,
  output logic       lamp_rev,
  output logic       lamp_pause,
  output logic       done,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones
);
  import wash_pkg::*;

  state_e     state_q;
  phase_e     phase;
  logic       start_rise;
  logic       launch;
  logic       min_pulse;
  logic       at_one;
  logic [7:0] digits;
  logic       running;

  assign running = (state_q == ST_RUN);
  assign launch  = start_rise & ~running;

  wash_edge u_edge (
    .clk  (clk),
    .lvl  (start_btn),
    .rise (start_rise)
  );

  wash_phase_timer #(
    .FWD_S   (FWD_S),
    .RESTA_S (RESTA_S),
    .REV_S   (REV_S),
    .RESTB_S (RESTB_S)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear     (launch),
    .run       (running),
    .tick      (sec_tick),
    .phase     (phase),
    .min_pulse (min_pulse)
  );

  wash_bcd_down #(
    .NDIG   (2),
    .PRESET (PRESET)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .load   (launch),
    .dec    (min_pulse),
    .digits (digits),
    .at_one (at_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else if (launch) begin
      state_q <= ST_RUN;
    end else if (min_pulse && at_one) begin
      state_q <= ST_FIN;
    end
  end

  always_comb begin
    lamp_fwd   = 1'b0;
    lamp_rev   = 1'b0;
    lamp_pause = 1'b0;
    if (running) begin
      case (phase)
        PH_FWD:  lamp_fwd   = 1'b1;
        PH_REV:  lamp_rev   = 1'b1;
        default: lamp_pause = 1'b1;
      endcase
    end
  end

  assign done     = (state_q == ST_FIN);
  assign min_tens = digits[7:4];
  assign min_ones = digits[3:0];
endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_btn,
  input logic       sec_tick,
  input logic       lamp_fwd,
  input logic       lamp_rev,
  input logic       lamp_pause,
  input logic       done,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones
);
  logic [2:0] lamps;
  assign lamps = {lamp_fwd, lamp_rev, lamp_pause};

  // R4
  lamp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lamps) && !(done && lamps != 3'b000));

  // R5
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    min_tens <= 4'd9 && min_ones <= 4'd9);

  // R5
  count_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_tick && !(start_btn && !$past(start_btn)) |=> $stable({min_tens, min_ones}));

  // R3
  phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_tick && !(start_btn && !$past(start_btn)) |=> $stable(lamps));

  // R3
  no_direct_flip_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_fwd |=> !lamp_rev);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done && !(start_btn && !$past(start_btn)) |=> done && min_tens == 4'd0 && min_ones == 4'd0);

  // R2
  launch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start_btn && !$past(start_btn)) && lamps == 3'b000
      |=> lamp_fwd && !done && min_tens == 4'd1 && min_ones == 4'd5);
endmodule

bind wash_sequencer wash_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_btn  (start_btn),
  .sec_tick   (sec_tick),
  .lamp_fwd   (lamp_fwd),
  .lamp_rev   (lamp_rev),
  .lamp_pause (lamp_pause),
  .done       (done),
  .min_tens   (min_tens),
  .min_ones   (min_ones)
);

// File: tb/sim_wash_sequencer.sv
module sim_wash_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_btn = 1'b0;
  logic       sec_tick = 1'b0;
  logic       lamp_fwd, lamp_rev, lamp_pause, done;
  logic [3:0] min_tens, min_ones;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wash_sequencer u0 (
    .clk        (clk),
    .rst        (rst),
    .start_btn  (start_btn),
    .sec_tick   (sec_tick),
    .lamp_fwd   (lamp_fwd),
    .lamp_rev   (lamp_rev),
    .lamp_pause (lamp_pause),
    .done       (done),
    .min_tens   (min_tens),
    .min_ones   (min_ones)
  );

  // {ticks[9:0], lamps fwd/rev/pause[2:0], tens[3:0], ones[3:0], done}
  localparam logic [21:0] VEC [14] = '{
    {10'd0,   3'b100, 4'd1, 4'd5, 1'b0},
    {10'd19,  3'b100, 4'd1, 4'd5, 1'b0},
    {10'd1,   3'b001, 4'd1, 4'd5, 1'b0},
    {10'd10,  3'b010, 4'd1, 4'd5, 1'b0},
    {10'd19,  3'b010, 4'd1, 4'd5, 1'b0},
    {10'd1,   3'b001, 4'd1, 4'd5, 1'b0},
    {10'd9,   3'b001, 4'd1, 4'd5, 1'b0},
    {10'd1,   3'b100, 4'd1, 4'd4, 1'b0},
    {10'd240, 3'b100, 4'd1, 4'd0, 1'b0},
    {10'd60,  3'b100, 4'd0, 4'd9, 1'b0},
    {10'd480, 3'b100, 4'd0, 4'd1, 1'b0},
    {10'd59,  3'b001, 4'd0, 4'd1, 1'b0},
    {10'd1,   3'b000, 4'd0, 4'd0, 1'b1},
    {10'd5,   3'b000, 4'd0, 4'd0, 1'b1}
  };

  function automatic logic [11:0] observed();
    return {lamp_fwd, lamp_rev, lamp_pause, min_tens, min_ones, done};
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    logic [11:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got lamps=%b digits=%h done=%b expected lamps=%b digits=%h done=%b",
               tag, got[11:9], got[8:1], got[0], exp[11:9], exp[8:1], exp[0]);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
    end
  endtask

  task automatic press();
    @(negedge clk) start_btn = 1'b1;
    @(negedge clk) start_btn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", {3'b000, 8'h00, 1'b0});

    ticks(5);
    check("R8 ticks while idle", {3'b000, 8'h00, 1'b0});

    press();
    for (int v = 0; v < 14; v++) begin
      ticks(int'(VEC[v][21:12]));
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", v), VEC[v][11:0]);
    end

    ticks(20);
    check("R6 R8 done holds under ticks", {3'b000, 8'h00, 1'b1});

    @(negedge clk) start_btn = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 restart after done", {3'b100, 8'h15, 1'b0});

    ticks(25);
    check("R7 held start does not retrigger", {3'b001, 8'h15, 1'b0});
    @(negedge clk) start_btn = 1'b0;
    press();
    ticks(5);
    check("R7 start edge while running ignored", {3'b010, 8'h15, 1'b0});

    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset during run", {3'b000, 8'h00, 1'b0});

    ticks(3);
    check("R8 ticks after reset", {3'b000, 8'h00, 1'b0});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before the run completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule